// File: doc/BRIEF.md
# Per-Processor Interrupt Signalling Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers a single candidate, made of an ID and an 8-bit priority where a lower value means more urgent. The block decides whether that candidate may interrupt the processor. The candidate must clear the processor's priority threshold and must outrank whatever the processor is already servicing. When both hold, and signalling is switched on, the block raises a registered interrupt request line.

Software talks to the block through a 32-bit register port with four word registers:

| Select | Register | Access |
|---|---|---|
| 0 | Control | bit 0 = signalling enable |
| 1 | Threshold | bits [7:0] = priority mask |
| 2 | Claim | read only |
| 3 | Completion | write only |

A read of the claim register returns the candidate's ID and pulses an acknowledge strobe back to the distributor. The candidate becomes active and is pushed onto a small stack of in-service interrupts. Writing the ID of the most recent active interrupt to the completion register retires it. A claim read that finds nothing eligible returns the reserved code 1023, which marks the read as spurious.

Top module: `cpu_irq_iface`

## Requirements
- R1: A claim read (select 2) that finds an eligible candidate returns the candidate ID in bits [9:0] of the read data, with bits [31:10] zero, in the same cycle as the read.
- R2: A claim read with no eligible candidate returns 1023 and leaves the acknowledge strobe low.
- R3: A candidate whose ID is above 1019 is never eligible. It is never signalled and never returned by a claim read.
- R4: A candidate is eligible only when its priority value is strictly below the 8-bit threshold held at select 1.
- R5: Control bit 0 (select 0) gates signalling. While it is 0, the request line stays low and claim reads return 1023.
- R6: The request line is a register. After each clock edge it equals the eligibility evaluated just before that edge, except when a claim was taken at that edge.
- R7: A successful claim raises the acknowledge strobe with ackId equal to the returned ID in the same cycle, makes the interrupt active, and drops the request line on the next cycle. A candidate whose priority value is equal to or above that of the most recent active interrupt is then not eligible.
- R8: While interrupts are active, a candidate whose priority value is strictly below that of the most recent active interrupt is eligible. This nesting works up to STACK_DEPTH levels. When the stack is full, no candidate is eligible.
- R9: A completion write (select 3) whose bits [9:0] match the most recent active interrupt retires it. A completion write that does not match, or that arrives when nothing is active, changes nothing.
- R10: After reset the request line is low, control and threshold read back 0, and no interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select: 0 control, 1 threshold, 2 claim, 3 completion |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from the select and the current state |
| candValid | input | 1 | Distributor has a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candPrio | input | 8 | Candidate priority, lower value is more urgent |
| ackStrobe | output | 1 | Claim taken this cycle |
| ackId | output | 10 | ID being claimed |
| irqOut | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume that the register port never raises a read and a write in the same cycle. They also assume that the candidate inputs stay stable from the start of a cycle until the clock edge. The bench drives every input once per cycle, on the falling edge, and asserts at most one strobe per cycle. This holds in the random phase as well. In that phase the candidate ID and priority are drawn freely, including IDs in the reserved range, so the ID and priority checks see their boundary values.

// File: rtl/irqif_pkg.sv
package irqif_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [ID_W-1:0] MAX_REAL_ID = 10'd1019;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_PMASK = 2'd1,
    SEL_CLAIM = 2'd2,
    SEL_DONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrPmask;
    logic    doAck;
    logic    doEoi;
    regSel_e rdSel;
  } ifStrobes_t;
endpackage

// File: rtl/irqif_ctrl.sv
module irqif_ctrl
  import irqif_pkg::*;
(
  input  logic            wrEn,
  input  logic            rdEn,
  input  regSel_e         addr,
  input  logic [ID_W-1:0] eoiId,
  input  logic            elig,
  input  logic            topValid,
  input  logic [ID_W-1:0] topId,
  output ifStrobes_t      st
);
  always_comb begin
    st.wrCtrl  = wrEn && (addr == SEL_CTRL);
    st.wrPmask = wrEn && (addr == SEL_PMASK);
    st.doAck   = rdEn && (addr == SEL_CLAIM) && elig;
    st.doEoi   = wrEn && (addr == SEL_DONE) && topValid && (eoiId == topId);
    st.rdSel   = addr;
  end
endmodule

// File: rtl/irqif_dpath.sv
module irqif_dpath
  import irqif_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PRIO_W      = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ifStrobes_t        st,
  input  logic [DATA_W-1:0] wrData,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              elig,
  output logic              topValid,
  output logic [ID_W-1:0]   topId
);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic              ctrlEn;
  logic [PRIO_W-1:0] pmask;
  logic [CNT_W-1:0]  depthCnt;
  logic [ID_W-1:0]   stackId   [STACK_DEPTH];
  logic [PRIO_W-1:0] stackPrio [STACK_DEPTH];
  logic              irqQ;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  pushIdx;
  logic [PRIO_W-1:0] topPrio;
  logic              stackFull;

  assign topValid  = (depthCnt != '0);
  assign stackFull = (depthCnt == CNT_W'(STACK_DEPTH));
  assign topIdx    = IDX_W'(depthCnt - 1'b1);
  assign pushIdx   = IDX_W'(depthCnt);
  assign topId     = stackId[topIdx];
  assign topPrio   = stackPrio[topIdx];

  always_comb begin
    elig = ctrlEn && candValid && (candId <= MAX_REAL_ID) &&
           (candPrio < pmask) && !stackFull &&
           (!topValid || (candPrio < topPrio));
  end

  always_comb begin
    rdData = '0;
    unique case (st.rdSel)
      SEL_CTRL:  rdData[0] = ctrlEn;
      SEL_PMASK: rdData[PRIO_W-1:0] = pmask;
      SEL_CLAIM: rdData[ID_W-1:0] = elig ? candId : SPURIOUS_ID;
      default:   rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      pmask    <= '0;
      depthCnt <= '0;
      irqQ     <= 1'b0;
    end else begin
      if (st.wrCtrl)  ctrlEn <= wrData[0];
      if (st.wrPmask) pmask  <= wrData[PRIO_W-1:0];
      if (st.doAck)      depthCnt <= depthCnt + 1'b1;
      else if (st.doEoi) depthCnt <= depthCnt - 1'b1;
      irqQ <= elig && !st.doAck;
    end
  end

  for (genvar g = 0; g < STACK_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stackId[g]   <= '0;
        stackPrio[g] <= '0;
      end else if (st.doAck && (pushIdx == IDX_W'(g))) begin
        stackId[g]   <= candId;
        stackPrio[g] <= candPrio;
      end
    end
  end

  assign irqOut = irqQ;

  p_irq_drop_after_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.doAck |=> !irqOut);
  p_ack_pushes_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.doAck |=> depthCnt == CNT_W'($past(depthCnt) + 1'b1));
  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> !irqOut);
  p_ack_real_id_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.doAck |-> candId <= MAX_REAL_ID);
  p_ack_under_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.doAck |-> candPrio < pmask);
  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    depthCnt <= CNT_W'(STACK_DEPTH));
  p_eoi_pops_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.doEoi |=> depthCnt == CNT_W'($past(depthCnt) - 1'b1));
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import irqif_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PRIO_W      = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              candValid,
  input  logic [9:0]        candId,
  input  logic [PRIO_W-1:0] candPrio,
  output logic              ackStrobe,
  output logic [9:0]        ackId,
  output logic              irqOut
);
  ifStrobes_t      strobes;
  logic            elig;
  logic            topValid;
  logic [ID_W-1:0] topId;

  irqif_ctrl u_ctrl (
    .wrEn     (regWrEn),
    .rdEn     (regRdEn),
    .addr     (regSel_e'(regAddr)),
    .eoiId    (regWrData[ID_W-1:0]),
    .elig     (elig),
    .topValid (topValid),
    .topId    (topId),
    .st       (strobes)
  );

  irqif_dpath #(
    .DATA_W      (DATA_W),
    .PRIO_W      (PRIO_W),
    .STACK_DEPTH (STACK_DEPTH)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .wrData    (regWrData),
    .candValid (candValid),
    .candId    (candId),
    .candPrio  (candPrio),
    .rdData    (regRdData),
    .irqOut    (irqOut),
    .elig      (elig),
    .topValid  (topValid),
    .topId     (topId)
  );

  assign ackStrobe = strobes.doAck;
  assign ackId     = candId;
endmodule

// File: tb/cpu_irq_iface_tb.sv
module cpu_irq_iface_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int OP_IDLE = 0, OP_WCTRL = 1, OP_WPM = 2, OP_ACK = 3, OP_EOI = 4;
  localparam int OP_RDCTRL = 5, OP_RDPM = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic candValid = 1'b0;
  logic [9:0] candId = '0;
  logic [7:0] candPrio = '0;
  logic ackStrobe;
  logic [9:0] ackId;
  logic irqOut;

  int checks = 0, failures = 0;
  bit mEn = 0;
  logic [7:0] mPm = 0;
  int mDepth = 0;
  logic [9:0] mId [DEPTH];
  logic [7:0] mPr [DEPTH];
  bit expIrq = 0;

  cpu_irq_iface #(.STACK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .candValid(candValid), .candId(candId), .candPrio(candPrio),
    .ackStrobe(ackStrobe), .ackId(ackId), .irqOut(irqOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit modelElig(logic cv, logic [9:0] id, logic [7:0] pr);
    if (!mEn || !cv || id > 10'd1019 || pr >= mPm || mDepth >= DEPTH) return 0;
    if (mDepth > 0 && pr >= mPr[mDepth-1]) return 0;
    return 1;
  endfunction

  task automatic step(string tag, int op, logic [31:0] wd,
                      logic cv, logic [9:0] cid, logic [7:0] cp);
    bit e;
    @(negedge clk);
    check({tag, " R6 irqOut"}, {31'd0, irqOut}, {31'd0, expIrq});
    candValid = cv; candId = cid; candPrio = cp; regWrData = wd;
    regWrEn = (op == OP_WCTRL || op == OP_WPM || op == OP_EOI);
    regRdEn = (op == OP_ACK || op == OP_RDCTRL || op == OP_RDPM);
    case (op)
      OP_WCTRL, OP_RDCTRL: regAddr = 2'd0;
      OP_WPM, OP_RDPM:     regAddr = 2'd1;
      OP_ACK:              regAddr = 2'd2;
      default:             regAddr = 2'd3;
    endcase
    #1;
    e = modelElig(cv, cid, cp);
    if (op == OP_ACK) begin
      check({tag, e ? " R1 claim id" : " R2 spurious"}, regRdData,
            e ? {22'd0, cid} : 32'd1023);
      check({tag, " R7 ack strobe"}, {31'd0, ackStrobe}, {31'd0, e});
      if (e) check({tag, " R7 ackId"}, {22'd0, ackId}, {22'd0, cid});
    end
    if (op == OP_RDCTRL) check({tag, " ctrl read"}, regRdData, {31'd0, mEn});
    if (op == OP_RDPM) check({tag, " pmask read"}, regRdData, {24'd0, mPm});
    @(posedge clk);
    if (op == OP_WCTRL) mEn = wd[0];
    if (op == OP_WPM) mPm = wd[7:0];
    if (op == OP_ACK && e) begin
      mId[mDepth] = cid; mPr[mDepth] = cp; mDepth++;
    end
    if (op == OP_EOI && mDepth > 0 && wd[9:0] == mId[mDepth-1]) mDepth--;
    expIrq = e && !(op == OP_ACK);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R10 reset state
    step("R10", OP_RDCTRL, 0, 0, 0, 0);
    step("R10", OP_RDPM, 0, 0, 0, 0);
    step("R10", OP_WCTRL, 1, 1, 10'd40, 8'h10);
    // R4: threshold 0 masks everything
    step("R4", OP_ACK, 0, 1, 10'd40, 8'h10);
    step("R4", OP_WPM, 32'hF0, 1, 10'd40, 8'h10);
    step("R4", OP_WPM, 32'h10, 1, 10'd40, 8'h10);
    step("R4", OP_ACK, 0, 1, 10'd40, 8'h10);
    step("R4", OP_WPM, 32'hF0, 1, 10'd40, 8'h10);
    step("R1", OP_IDLE, 0, 1, 10'd40, 8'h10);
    step("R1", OP_ACK, 0, 1, 10'd40, 8'h10);
    // R7: same priority while active
    step("R7", OP_IDLE, 0, 1, 10'd40, 8'h10);
    step("R7", OP_ACK, 0, 1, 10'd41, 8'h10);
    // R8: higher priority nests
    step("R8", OP_IDLE, 0, 1, 10'd50, 8'h08);
    step("R8", OP_ACK, 0, 1, 10'd50, 8'h08);
    // R9: mismatched completion ignored
    step("R9", OP_EOI, 40, 1, 10'd60, 8'h0C);
    step("R9", OP_IDLE, 0, 1, 10'd60, 8'h0C);
    step("R9", OP_ACK, 0, 1, 10'd60, 8'h0C);
    step("R9", OP_EOI, 50, 1, 10'd60, 8'h0C);
    step("R9", OP_IDLE, 0, 1, 10'd60, 8'h0C);
    step("R9", OP_ACK, 0, 1, 10'd60, 8'h0C);
    step("R9", OP_EOI, 60, 0, 0, 0);
    step("R9", OP_EOI, 40, 0, 0, 0);
    step("R9", OP_EOI, 40, 0, 0, 0);
    // R3: reserved IDs
    step("R3", OP_ACK, 0, 1, 10'd1020, 8'h00);
    step("R3", OP_ACK, 0, 1, 10'd1023, 8'h00);
    step("R3", OP_ACK, 0, 1, 10'd1019, 8'h00);
    step("R3", OP_EOI, 1019, 0, 0, 0);
    // R8: full stack
    step("R8", OP_ACK, 0, 1, 10'd1, 8'h40);
    step("R8", OP_ACK, 0, 1, 10'd2, 8'h30);
    step("R8", OP_ACK, 0, 1, 10'd3, 8'h20);
    step("R8", OP_ACK, 0, 1, 10'd4, 8'h10);
    step("R8", OP_IDLE, 0, 1, 10'd5, 8'h05);
    step("R8", OP_ACK, 0, 1, 10'd5, 8'h05);
    step("R8", OP_EOI, 4, 1, 10'd5, 8'h05);
    step("R8", OP_ACK, 0, 1, 10'd5, 8'h05);
    for (int k = 5; k >= 1; k--) step("R8", OP_EOI, k, 0, 0, 0);
    // R5: disable gates signalling
    step("R5", OP_IDLE, 0, 1, 10'd9, 8'h01);
    step("R5", OP_WCTRL, 0, 1, 10'd9, 8'h01);
    step("R5", OP_IDLE, 0, 1, 10'd9, 8'h01);
    step("R5", OP_ACK, 0, 1, 10'd9, 8'h01);
    step("R5", OP_WCTRL, 1, 1, 10'd9, 8'h01);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r, op;
      logic [31:0] wd;
      logic [9:0] id;
      r = int'($urandom_range(0, 99));
      op = (r < 35) ? OP_ACK : (r < 60) ? OP_EOI : (r < 68) ? OP_WPM :
           (r < 72) ? OP_WCTRL : (r < 76) ? OP_RDPM : OP_IDLE;
      id = ($urandom_range(0, 9) == 0) ? 10'($urandom_range(1015, 1023))
                                       : 10'($urandom_range(0, 1019));
      wd = $urandom;
      if (op == OP_WCTRL) wd = ($urandom_range(0, 3) == 0) ? 32'd0 : 32'd1;
      if (op == OP_EOI && mDepth > 0 && $urandom_range(0, 1) == 1)
        wd = {22'd0, mId[mDepth-1]};
      step("RND", op, wd, 1'($urandom_range(0, 4) != 0), id, 8'($urandom));
    end
    step("END", OP_IDLE, 0, 0, 0, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule